// File: doc/BRIEF.md
# Block-transfer register sequencer

This block steps a load-multiple or store-multiple operation through a load/store unit whose data path is 64 bits wide, so that up to two 32-bit registers move in each beat. A one-cycle start pulse hands it a 16-bit register list, a base byte address and a direction flag. From the next cycle on, the sequencer presents one beat per cycle. Each beat carries up to two register indices, the word address of the first slot, and a valid bit for each slot. The second slot always sits at the following word. Every beat is assumed to hit in the data cache and to complete in its own cycle.

Registers go out in ascending index order, at consecutive word addresses counted up from the base. Two registers can share a beat only when the first of them lands on a 64-bit boundary. When the base is one word past such a boundary, the opening beat carries a single register to restore alignment. For a register count n, that costs one beat more than the aligned ceil(n/2) when n is even. While a transfer is in flight the ALU stall output stays high, up to and including the beat that carries the last register. A done pulse marks that beat.

Top module: `ldm_seq`

## Requirements
- R1: While reset is asserted, and while the sequencer is idle afterwards, alu_stall_o, done_o and both bits of slot_vld_o are 0. Reset is asynchronous. Its release is synchronised over two clock edges, and an asserted reset abandons any transfer in flight.
- R2: A start_i pulse sampled while idle captures reglist_i, base_i and load_i. In the following cycle alu_stall_o is 1 and the first beat is presented.
- R3: Slot 0 (slot_reg_o[3:0]) carries the lowest-indexed register still pending. Slot 1 (slot_reg_o[7:4]) carries the next-lowest pending register above it.
- R4: slot_vld_o bit 0 qualifies slot 0 and bit 1 qualifies slot 1. When beat_addr_o bit 2 is 0 and two or more registers are pending, both slots are valid. Slot 1 is never valid without slot 0.
- R5: When beat_addr_o bit 2 is 1, only slot 0 is valid. A list of n registers therefore takes ceil(n/2) beats from an aligned base, and 1 + ceil((n-1)/2) beats from a base with bit 2 set.
- R6: The first beat's beat_addr_o equals the captured base. Each later beat's address is the previous one plus 4 for every valid slot in the previous beat.
- R7: done_o is 1 exactly in the beat that transfers the last pending register. alu_stall_o is 1 in every cycle from the one after start through that beat, and 0 in the cycle after it.
- R8: An all-zero register list gives one cycle, the one after start, in which done_o and alu_stall_o are 1 and no slot is valid.
- R9: A start_i pulse while a transfer is in flight is ignored. The running sequence of registers and addresses continues unchanged and no new transfer follows.
- R10: beat_load_o holds the load_i value captured at start for the whole transfer. Changes on load_i, reglist_i or base_i during the transfer have no effect on the beats.
- R11: Every register set in the captured list is transferred exactly once, and no register outside the list is transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a transfer |
| reglist_i | input | 16 | Register list, bit i selects register i |
| base_i | input | 32 | Byte address of the first word (word aligned) |
| load_i | input | 1 | 1 for a load, 0 for a store |
| slot_vld_o | output | 2 | Per-slot valid for the current beat |
| slot_reg_o | output | 8 | Slot 0 index in bits 3:0, slot 1 index in bits 7:4 |
| beat_addr_o | output | 32 | Word address of slot 0; slot 1 uses this plus 4 |
| beat_load_o | output | 1 | Direction of the transfer in progress |
| alu_stall_o | output | 1 | Holds the ALU pipeline while the transfer runs |
| done_o | output | 1 | Marks the beat carrying the final register |

## Verification
The properties assume that base_i is word aligned, with bits 1:0 at zero, so that bit 2 alone decides whether a beat may pair. They also assume that start_i is raised only after the two-edge reset release has completed. The stimulus uses only word-aligned bases and drives start_i well after reset release. Aligned and misaligned bases are mixed in the stimulus. It also applies empty, single, sparse and full register lists, a start pulse with altered inputs in the middle of a transfer, and a reset asserted in the middle of a transfer.

// File: rtl/ldm_pkg.sv
package ldm_pkg;

  typedef enum logic {
    LDM_IDLE = 1'b0,
    LDM_RUN  = 1'b1
  } ldm_state_e;

endpackage

// File: rtl/ldm_rst_sync.sv
module ldm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_q_n = sync_q[STAGES-1];

endmodule

// File: rtl/ldm_lowbit.sv
module ldm_lowbit #(
  parameter int W  = 16,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o,
  output logic [W-1:0]  onehot_o
);

  always_comb begin
    found_o = |vec_i;
    idx_o   = '0;
    // scan from the top so the lowest set bit wins
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end

  assign onehot_o = vec_i & (~vec_i + W'(1));

endmodule

// File: rtl/ldm_seq.sv
module ldm_seq #(
  parameter int NREGS  = 16,
  parameter int AW     = 32,
  parameter int WORD_W = 32,
  parameter int BEAT_W = 64,
  localparam int IW    = $clog2(NREGS),
  localparam int NSLOT = BEAT_W / WORD_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [NREGS-1:0]    reglist_i,
  input  logic [AW-1:0]       base_i,
  input  logic                load_i,
  output logic [NSLOT-1:0]    slot_vld_o,
  output logic [NSLOT*IW-1:0] slot_reg_o,
  output logic [AW-1:0]       beat_addr_o,
  output logic                beat_load_o,
  output logic                alu_stall_o,
  output logic                done_o
);

  import ldm_pkg::*;

  localparam int WORD_LG = $clog2(WORD_W / 8);
  localparam int BEAT_LG = $clog2(BEAT_W / 8);
  localparam int OFFW    = BEAT_LG - WORD_LG;
  localparam int CNTW    = $clog2(NSLOT + 1);

  logic rst_q_n;

  ldm_state_e        state_q, state_d;
  logic [NREGS-1:0]  rem_q, rem_d;
  logic [AW-1:0]     addr_q, addr_d;
  logic              load_q;

  logic              running;
  logic              cap_en, state_en, rem_en, addr_en;
  logic              last_beat;
  logic [OFFW-1:0]   woff;
  logic [NREGS-1:0]  taken, rem_left;
  logic [CNTW-1:0]   nvld;

  logic [NREGS-1:0]  chain   [NSLOT+1];
  logic [NREGS-1:0]  oh      [NSLOT];
  logic [NREGS-1:0]  take    [NSLOT];
  logic [NSLOT-1:0]  found;
  logic [NSLOT-1:0]  slot_ok;
  logic [IW-1:0]     idx     [NSLOT];

  ldm_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  assign running  = (state_q == LDM_RUN);
  assign woff     = addr_q[BEAT_LG-1:WORD_LG];
  assign chain[0] = running ? rem_q : '0;

  // one picker per slot, each seeing the list minus earlier picks
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    ldm_lowbit #(.W(NREGS)) u_pick (
      .vec_i    (chain[s]),
      .found_o  (found[s]),
      .idx_o    (idx[s]),
      .onehot_o (oh[s])
    );
    assign chain[s+1]          = chain[s] & ~oh[s];
    assign slot_ok[s]          = (int'(woff) + s) < NSLOT;
    assign slot_vld_o[s]       = found[s] & slot_ok[s];
    assign take[s]             = slot_vld_o[s] ? oh[s] : '0;
    assign slot_reg_o[s*IW +: IW] = idx[s];
  end

  always_comb begin
    taken = '0;
    nvld  = '0;
    for (int s = 0; s < NSLOT; s++) begin
      taken = taken | take[s];
      nvld  = nvld + CNTW'(slot_vld_o[s]);
    end
  end

  assign rem_left  = rem_q & ~taken;
  assign last_beat = running && (rem_left == '0);
  assign cap_en    = !running && start_i;

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LDM_IDLE: if (start_i)   state_d = LDM_RUN;
      LDM_RUN:  if (last_beat) state_d = LDM_IDLE;
      default:                 state_d = LDM_IDLE;
    endcase
  end

  assign state_en = cap_en | last_beat;
  assign rem_en   = cap_en | running;
  assign addr_en  = cap_en | (running && !last_beat);
  assign rem_d    = cap_en ? reglist_i : rem_left;
  assign addr_d   = cap_en ? base_i : (addr_q + (AW'(nvld) << WORD_LG));

  // registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q <= LDM_IDLE;
      rem_q   <= '0;
      addr_q  <= '0;
      load_q  <= 1'b0;
    end else begin
      if (state_en) state_q <= state_d;
      if (rem_en)   rem_q   <= rem_d;
      if (addr_en)  addr_q  <= addr_d;
      if (cap_en)   load_q  <= load_i;
    end
  end

  assign beat_addr_o = addr_q;
  assign beat_load_o = load_q;
  assign alu_stall_o = running;
  assign done_o      = last_beat;

endmodule

// File: rtl/ldm_seq_chk.sv
module ldm_seq_chk #(
  parameter int AW      = 32,
  parameter int IW      = 4,
  parameter int NSLOT   = 2,
  parameter int WORD_LG = 2,
  parameter int BEAT_LG = 3
) (
  input logic                clk,
  input logic                rst_q_n,
  input logic                start_i,
  input logic [NSLOT-1:0]    slot_vld_o,
  input logic [NSLOT*IW-1:0] slot_reg_o,
  input logic [AW-1:0]       beat_addr_o,
  input logic                beat_load_o,
  input logic                alu_stall_o,
  input logic                done_o
);

  logic [AW-1:0] step;
  assign step = AW'($countones(slot_vld_o)) << WORD_LG;

  // R4
  pair_needs_first_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    slot_vld_o[1] |-> slot_vld_o[0]);

  // R3
  slot_ascending_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (&slot_vld_o) |-> (slot_reg_o[2*IW-1:IW] > slot_reg_o[IW-1:0]));

  // R5
  misaligned_single_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    slot_vld_o[1] |-> (beat_addr_o[BEAT_LG-1:WORD_LG] == '0));

  // R2
  start_stalls_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (start_i && !alu_stall_o) |=> alu_stall_o);

  // R7
  done_releases_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    done_o |=> !alu_stall_o);

  // R7
  stall_holds_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (alu_stall_o && !done_o) |=> alu_stall_o);

  // R7
  beat_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (slot_vld_o[0] || done_o) |-> alu_stall_o);

  // R6
  addr_advance_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (slot_vld_o[0] && !done_o) |=> (beat_addr_o == $past(beat_addr_o) + $past(step)));

  // R10
  dir_stable_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (alu_stall_o && !done_o) |=> $stable(beat_load_o));

endmodule

bind ldm_seq ldm_seq_chk #(
  .AW      (AW),
  .IW      (IW),
  .NSLOT   (NSLOT),
  .WORD_LG (WORD_LG),
  .BEAT_LG (BEAT_LG)
) u_ldm_seq_chk (
  .clk         (clk),
  .rst_q_n     (rst_q_n),
  .start_i     (start_i),
  .slot_vld_o  (slot_vld_o),
  .slot_reg_o  (slot_reg_o),
  .beat_addr_o (beat_addr_o),
  .beat_load_o (beat_load_o),
  .alu_stall_o (alu_stall_o),
  .done_o      (done_o)
);

// File: tb/test_ldm_seq.sv
`timescale 1ns/1ps
module test_ldm_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [15:0] reglist_i;
  logic [31:0] base_i;
  logic        load_i;
  logic [1:0]  slot_vld_o;
  logic [7:0]  slot_reg_o;
  logic [31:0] beat_addr_o;
  logic        beat_load_o;
  logic        alu_stall_o;
  logic        done_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  ldm_seq i_ldm_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .reglist_i   (reglist_i),
    .base_i      (base_i),
    .load_i      (load_i),
    .slot_vld_o  (slot_vld_o),
    .slot_reg_o  (slot_reg_o),
    .beat_addr_o (beat_addr_o),
    .beat_load_o (beat_load_o),
    .alu_stall_o (alu_stall_o),
    .done_o      (done_o)
  );

  typedef struct packed {
    logic [15:0] mask;
    logic [31:0] base;
    logic        ld;
    logic [7:0]  beats;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{16'hFFFF, 32'h0000_1000, 1'b1, 8'd8},
    '{16'hFFFF, 32'h0000_1004, 1'b1, 8'd9},
    '{16'h0001, 32'h0000_0800, 1'b0, 8'd1},
    '{16'h0001, 32'h0000_2004, 1'b1, 8'd1},
    '{16'h0003, 32'h0000_3004, 1'b0, 8'd2},
    '{16'h0007, 32'h0000_0040, 1'b1, 8'd2},
    '{16'h0007, 32'h0000_0044, 1'b0, 8'd2},
    '{16'h8421, 32'h0000_0000, 1'b1, 8'd2},
    '{16'h00F0, 32'h0000_00FC, 1'b1, 8'd3},
    '{16'hA000, 32'h0000_0010, 1'b0, 8'd1}
  };

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic run_xfer(input logic [15:0] m, input logic [31:0] b,
                          input logic ld, input int exp_beats, input bit disturb);
    logic [15:0] rem, rem2, left, moved;
    logic [31:0] a;
    int beats, e0, e1;
    bit v0, v1, fin;
    string t_idx, t_done;
    t_idx  = disturb ? "R9" : "R3";
    t_done = (m == 16'h0) ? "R8" : "R7";
    @(negedge clk);
    reglist_i = m; base_i = b; load_i = ld; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    rem = m; a = b; beats = 0; fin = 1'b0; moved = '0;
    for (int cyc = 0; cyc < 24 && !fin; cyc++) begin
      if (cyc == 1) start_i = 1'b0;
      v0 = (rem != 16'h0); v1 = 1'b0; e0 = 0; e1 = 0;
      for (int i = 15; i >= 0; i--) if (rem[i]) e0 = i;
      rem2 = v0 ? (rem & ~(16'h1 << e0)) : rem;
      if (v0 && !a[2] && rem2 != 16'h0) begin
        v1 = 1'b1;
        for (int i = 15; i >= 0; i--) if (rem2[i]) e1 = i;
      end
      left = v1 ? (rem2 & ~(16'h1 << e1)) : rem2;
      fin  = (left == 16'h0);
      if (cyc == 0) chk("R2", "stall after start", 64'(alu_stall_o), 64'd1);
      else          chk("R7", "stall in transfer", 64'(alu_stall_o), 64'd1);
      chk(v1 ? "R4" : "R5", "slot valids", 64'(slot_vld_o), 64'({v1, v0}));
      if (v0) chk(t_idx, "slot0 reg", 64'(slot_reg_o[3:0]), 64'(e0));
      if (v1) chk(t_idx, "slot1 reg", 64'(slot_reg_o[7:4]), 64'(e1));
      if (v0) chk("R6", "beat address", 64'(beat_addr_o), 64'(a));
      if (v0) chk("R10", "direction", 64'(beat_load_o), 64'(ld));
      chk(t_done, "done", 64'(done_o), 64'(fin));
      if (v0) moved = moved | (16'h1 << e0);
      if (v1) moved = moved | (16'h1 << e1);
      rem = left;
      a = a + 32'(4 * (int'(v0) + int'(v1)));
      beats += int'(v0);
      if (disturb && cyc == 0) begin
        start_i = 1'b1; reglist_i = ~m; base_i = b ^ 32'h8; load_i = ~ld;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    chk("R7", "stall released", 64'(alu_stall_o), 64'd0);
    chk(disturb ? "R9" : "R1", "idle valids", 64'(slot_vld_o), 64'd0);
    chk("R5", "beat count", 64'(beats), 64'(exp_beats));
    chk("R11", "registers moved", 64'(moved), 64'(m));
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; reglist_i = '0; base_i = '0; load_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "stall in reset", 64'(alu_stall_o), 64'd0);
    chk("R1", "valids in reset", 64'(slot_vld_o), 64'd0);
    chk("R1", "done in reset", 64'(done_o), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "stall idle", 64'(alu_stall_o), 64'd0);

    for (int k = 0; k < NVEC; k++)
      run_xfer(VECS[k].mask, VECS[k].base, VECS[k].ld, int'(VECS[k].beats), 1'b0);

    // empty list
    run_xfer(16'h0000, 32'h0000_0040, 1'b1, 0, 1'b0);
    // start and input changes while busy
    run_xfer(16'hFFFF, 32'h0000_1000, 1'b1, 8, 1'b1);
    run_xfer(16'h0F0F, 32'h0000_0204, 1'b0, 5, 1'b1);

    // reset in the middle of a transfer
    @(negedge clk);
    reglist_i = 16'hFFFF; base_i = 32'h100; load_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1", "stall after mid reset", 64'(alu_stall_o), 64'd0);
    chk("R1", "valids after mid reset", 64'(slot_vld_o), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "idle after mid reset", 64'(alu_stall_o), 64'd0);
    run_xfer(16'h0006, 32'h0000_0008, 1'b0, 1, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule